// File: doc/BRIEF.md
# Configurable GPIO Pin Bank

A bank of general-purpose I/O pin slices, one slice per pin. Each slice has a programmable input path and output path. On the input side, the pad level passes through a two-flop synchronizer. It is then optionally inverted so that a high or a low level can count as "active". An optional filter on a slow timebase tick can then qualify it, and an optional sticky status bit can hold it. The selected status, gated by a per-pin enable, is routed to one of two shared interrupt request lines. The input path stays live whatever the output side is doing.

On the output side, each pin's pad value comes from a registered selector. The selector picks a constant low, a constant high, or one of two shared blink clocks. A separate registered enable drives the pad output enable. Software clears the sticky status with a one-cycle write-one-to-clear strobe per pin.

Top module: `gpio_pin_bank`

## Requirements
- R1: During and directly after reset, every padOut, padOe and intStatus bit is 0, and sciReq and smiReq are 0.
- R2: Per-pin control field (7 bits, pin p at cfgBus[7p+6:7p]): bit 0 drive enable, bits 2:1 output source, bit 3 active-low, bit 4 filter enable, bit 5 sticky select, bit 6 route (0 = SCI line, 1 = SMI line). The padOe output equals bit 0 one clock after it is applied.
- R3: Output source codes are 0 = low, 1 = high, 2 = blinkClk0, 3 = blinkClk1. padOut shows the selected value one clock after the inputs are applied, whatever the state of padOe.
- R4: With active-low set, a low pad level counts as active. With it clear, a high pad level counts as active. A pad change reaches an unfiltered, unlatched intStatus two clocks later.
- R5: With the filter disabled, the active level passes straight through to the status stage.
- R6: With the filter enabled, the filtered signal rises on the clock of the 4th consecutive tickSlow sample that sees the input active. Any tick that samples the input inactive restarts the count and drops the filtered signal. Between ticks the filtered signal holds.
- R7: With sticky select set, intStatus stays 1 after the filtered signal falls, until a statusClr pulse. If the set and the clear meet in the same cycle, the bit stays set.
- R8: With sticky select clear, intStatus follows the filtered signal directly.
- R9: sciReq is the OR over pins of intStatus AND intEn AND route==0. smiReq is the same with route==1.
- R10: The input path and the interrupt stay live while the pin drives its pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgBus | input | PINS*7 | Per-pin control fields |
| padIn | input | PINS | Pad input levels |
| padOut | output | PINS | Registered pad output values |
| padOe | output | PINS | Registered pad output enables |
| blinkClk0 | input | 1 | Shared blink clock 0 |
| blinkClk1 | input | 1 | Shared blink clock 1 |
| tickSlow | input | 1 | One-cycle filter sample tick (nominally every 4 ms) |
| intEn | input | PINS | Per-pin interrupt enables |
| statusClr | input | PINS | Per-pin write-one-to-clear strobes |
| intStatus | output | PINS | Per-pin interrupt status (sticky or direct) |
| sciReq | output | 1 | SCI request line |
| smiReq | output | 1 | SMI request line |

## Verification
The hardest behaviours to reach from the ports are two. One is a filter restart after a partial count. The other is a clear that lands in the same cycle as a set of the sticky status. The stimulus pulses tickSlow one cycle at a time while it holds or toggles the pad. It checks that three active ticks do not qualify, that an inactive tick in the middle restarts the count, and that the fourth active tick does qualify. For the collision, the pad is held active with sticky select on while a statusClr pulse is sent. The status must survive, and it must then fall with a later clear once the pad is inactive.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int CFG_W = 7;

  typedef enum logic [1:0] {
    SRC_LOW    = 2'd0,
    SRC_HIGH   = 2'd1,
    SRC_BLINK0 = 2'd2,
    SRC_BLINK1 = 2'd3
  } outSrc_t;

  typedef struct packed {
    logic filt;
    logic setLatch;
    logic clrLatch;
  } pinStrobe_t;
endpackage

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl #(
  parameter int PINS        = 2,
  parameter int DEB_SAMPLES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tickSlow,
  input  logic [PINS-1:0]               qualIn,
  input  logic [PINS-1:0]               debEn,
  input  logic [PINS-1:0]               clrIn,
  output gpio_pkg::pinStrobe_t [PINS-1:0] strobes
);
  localparam int CNT_W = $clog2(DEB_SAMPLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEB_SAMPLES);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [CNT_W-1:0] sampleCnt;
    logic             filtered;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sampleCnt <= '0;
      end else if (tickSlow) begin
        if (!qualIn[i])                sampleCnt <= '0;
        else if (sampleCnt != CNT_MAX) sampleCnt <= sampleCnt + 1'b1;
      end
    end

    assign filtered = debEn[i] ? (sampleCnt == CNT_MAX) : qualIn[i];

    always_comb begin
      strobes[i].filt     = filtered;
      strobes[i].setLatch = filtered;
      strobes[i].clrLatch = clrIn[i];
    end

    // R6
    filter_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
      (debEn[i] && $past(debEn[i]) && $rose(filtered)) |-> $past(tickSlow));
  end
endmodule

// File: rtl/gpio_pin_dp.sv
module gpio_pin_dp #(
  parameter int PINS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PINS-1:0]               padIn,
  input  logic [PINS-1:0]               oeV,
  input  logic [2*PINS-1:0]             srcV,
  input  logic [PINS-1:0]               actLowV,
  input  logic [PINS-1:0]               latchEnV,
  input  logic [PINS-1:0]               routeV,
  input  logic                          blinkClk0,
  input  logic                          blinkClk1,
  input  logic [PINS-1:0]               intEn,
  input  gpio_pkg::pinStrobe_t [PINS-1:0] strobes,
  output logic [PINS-1:0]               qualOut,
  output logic [PINS-1:0]               padOut,
  output logic [PINS-1:0]               padOe,
  output logic [PINS-1:0]               intStatus,
  output logic                          sciReq,
  output logic                          smiReq
);
  import gpio_pkg::*;

  logic [PINS-1:0] syncA, syncB, sticky;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  assign qualOut = syncB ^ actLowV;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic nextOut;

    always_comb begin
      unique case (outSrc_t'(srcV[2*i +: 2]))
        SRC_LOW:    nextOut = 1'b0;
        SRC_HIGH:   nextOut = 1'b1;
        SRC_BLINK0: nextOut = blinkClk0;
        default:    nextOut = blinkClk1;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        padOut[i] <= 1'b0;
        padOe[i]  <= 1'b0;
        sticky[i] <= 1'b0;
      end else begin
        padOut[i] <= nextOut;
        padOe[i]  <= oeV[i];
        sticky[i] <= (sticky[i] & ~strobes[i].clrLatch) | strobes[i].setLatch;
      end
    end

    assign intStatus[i] = latchEnV[i] ? sticky[i] : strobes[i].filt;

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sticky[i] && !strobes[i].clrLatch) |=> sticky[i]);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[i].setLatch && strobes[i].clrLatch) |=> sticky[i]);
  end

  assign sciReq = |(intStatus & intEn & ~routeV);
  assign smiReq = |(intStatus & intEn & routeV);

  // R9
  no_req_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|(intStatus & intEn)) |-> (!sciReq && !smiReq));

  // R2
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (padOe == $past(oeV)));
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int PINS        = 2,
  parameter int DEB_SAMPLES = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [PINS*gpio_pkg::CFG_W-1:0] cfgBus,
  input  logic [PINS-1:0]                padIn,
  output logic [PINS-1:0]                padOut,
  output logic [PINS-1:0]                padOe,
  input  logic                           blinkClk0,
  input  logic                           blinkClk1,
  input  logic                           tickSlow,
  input  logic [PINS-1:0]                intEn,
  input  logic [PINS-1:0]                statusClr,
  output logic [PINS-1:0]                intStatus,
  output logic                           sciReq,
  output logic                           smiReq
);
  import gpio_pkg::*;

  logic [PINS-1:0]   oeV, actLowV, debEnV, latchEnV, routeV, qualV;
  logic [2*PINS-1:0] srcV;
  pinStrobe_t [PINS-1:0] strobes;

  for (genvar i = 0; i < PINS; i++) begin : g_cfg
    assign oeV[i]          = cfgBus[CFG_W*i + 0];
    assign srcV[2*i +: 2]  = cfgBus[CFG_W*i + 1 +: 2];
    assign actLowV[i]      = cfgBus[CFG_W*i + 3];
    assign debEnV[i]       = cfgBus[CFG_W*i + 4];
    assign latchEnV[i]     = cfgBus[CFG_W*i + 5];
    assign routeV[i]       = cfgBus[CFG_W*i + 6];
  end

  gpio_pin_ctl #(.PINS(PINS), .DEB_SAMPLES(DEB_SAMPLES)) u_ctl (
    .clk(clk), .rstN(rstN), .tickSlow(tickSlow),
    .qualIn(qualV), .debEn(debEnV), .clrIn(statusClr), .strobes(strobes)
  );

  gpio_pin_dp #(.PINS(PINS)) u_dp (
    .clk(clk), .rstN(rstN), .padIn(padIn), .oeV(oeV), .srcV(srcV),
    .actLowV(actLowV), .latchEnV(latchEnV), .routeV(routeV),
    .blinkClk0(blinkClk0), .blinkClk1(blinkClk1), .intEn(intEn),
    .strobes(strobes), .qualOut(qualV), .padOut(padOut), .padOe(padOe),
    .intStatus(intStatus), .sciReq(sciReq), .smiReq(smiReq)
  );
endmodule

// File: tb/test_gpio_pin_bank.sv
module test_gpio_pin_bank;
  localparam int PINS = 2;
  localparam int NV   = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PINS*7-1:0] cfgBus = '0;
  logic [PINS-1:0] padIn = '0, intEn = '0, statusClr = '0;
  logic blinkClk0 = 1'b0, blinkClk1 = 1'b0, tickSlow = 1'b0;
  logic [PINS-1:0] padOut, padOe, intStatus;
  logic sciReq, smiReq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_pin_bank #(.PINS(PINS), .DEB_SAMPLES(4)) i_gpio_pin_bank (
    .clk(clk), .rstN(rstN), .cfgBus(cfgBus), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .blinkClk0(blinkClk0), .blinkClk1(blinkClk1),
    .tickSlow(tickSlow), .intEn(intEn), .statusClr(statusClr),
    .intStatus(intStatus), .sciReq(sciReq), .smiReq(smiReq)
  );

  // {cfg[6:0] (route,sticky,filter,actLow,src[1:0],oe), pad, en, b0, b1, out, oe, st, sci, smi}
  localparam logic [15:0] VEC [NV] = '{
    {7'b0000000, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
    {7'b0000011, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0},
    {7'b0000101, 1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0},
    {7'b0000101, 1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b0},
    {7'b0000111, 1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0,1'b0},
    {7'b0000001, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b1,1'b0},
    {7'b0001000, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,1'b0},
    {7'b0001000, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
    {7'b1000000, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b1},
    {7'b1000000, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0},
    {7'b0000010, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic tick();
    tickSlow = 1'b1; @(negedge clk); tickSlow = 1'b0; @(negedge clk);
  endtask

  task automatic clrPulse();
    statusClr[0] = 1'b1; @(negedge clk); statusClr[0] = 1'b0; @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    // R1 during reset
    check("R1 reset", {padOut, padOe, intStatus, sciReq, smiReq}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {padOut, padOe, intStatus, sciReq, smiReq}, 8'h00);

    // R2 R3 R4 R5 R8 R9 R10 vector walk on pin 0
    for (int v = 0; v < NV; v++) begin
      cfgBus[6:0] = VEC[v][15:9];
      padIn[0]    = VEC[v][8];
      intEn[0]    = VEC[v][7];
      blinkClk0   = VEC[v][6];
      blinkClk1   = VEC[v][5];
      waitClk(3);
      check($sformatf("R3 padOut vec%0d", v), {7'd0, padOut[0]}, {7'd0, VEC[v][4]});
      check($sformatf("R2 padOe vec%0d", v), {7'd0, padOe[0]}, {7'd0, VEC[v][3]});
      check($sformatf("R4 R10 status vec%0d", v), {7'd0, intStatus[0]}, {7'd0, VEC[v][2]});
      check($sformatf("R9 req vec%0d", v), {6'd0, sciReq, smiReq}, {6'd0, VEC[v][1:0]});
    end

    // R2 R3 one-clock latency
    cfgBus[6:0] = 7'b0000000; waitClk(2);
    cfgBus[6:0] = 7'b0000011; @(negedge clk);
    check("R3 latency", {6'd0, padOut[0], padOe[0]}, 8'h03);

    // R4 two-clock input latency
    cfgBus[6:0] = 7'b0000000; intEn[0] = 1'b1; padIn[0] = 1'b0; waitClk(3);
    padIn[0] = 1'b1; @(negedge clk);
    check("R4 one clock", {7'd0, intStatus[0]}, 8'h00);
    @(negedge clk);
    check("R4 two clocks", {7'd0, intStatus[0]}, 8'h01);
    // R8 falls with signal
    padIn[0] = 1'b0; waitClk(3);
    check("R8 direct fall", {7'd0, intStatus[0]}, 8'h00);

    // R6 filter
    cfgBus[6:0] = 7'b0010000; padIn[0] = 1'b1; waitClk(3);
    tick(); tick(); tick();
    check("R6 three ticks", {7'd0, intStatus[0]}, 8'h00);
    tick();
    check("R6 four ticks", {7'd0, intStatus[0]}, 8'h01);
    padIn[0] = 1'b0; waitClk(3);
    check("R6 hold between ticks", {7'd0, intStatus[0]}, 8'h01);
    tick();
    check("R6 inactive tick drops", {7'd0, intStatus[0]}, 8'h00);
    padIn[0] = 1'b1; waitClk(3); tick(); tick();
    padIn[0] = 1'b0; waitClk(3); tick();
    padIn[0] = 1'b1; waitClk(3); tick(); tick(); tick();
    check("R6 restart three", {7'd0, intStatus[0]}, 8'h00);
    tick();
    check("R6 restart four", {7'd0, intStatus[0]}, 8'h01);
    padIn[0] = 1'b0; waitClk(3); tick();

    // R7 sticky
    clrPulse();
    cfgBus[6:0] = 7'b0100000; padIn[0] = 1'b1; waitClk(3);
    check("R7 set", {7'd0, intStatus[0]}, 8'h01);
    padIn[0] = 1'b0; waitClk(3);
    check("R7 held", {7'd0, intStatus[0]}, 8'h01);
    clrPulse();
    check("R7 cleared", {7'd0, intStatus[0]}, 8'h00);
    padIn[0] = 1'b1; waitClk(3); clrPulse();
    check("R7 set wins", {7'd0, intStatus[0]}, 8'h01);
    padIn[0] = 1'b0; waitClk(3); clrPulse();
    check("R7 clear after", {7'd0, intStatus[0]}, 8'h00);

    // R9 two pins on different lines
    cfgBus = {7'b1000000, 7'b0000000}; intEn = 2'b11; padIn = 2'b11; waitClk(3);
    check("R9 both lines", {6'd0, sciReq, smiReq}, 8'h03);
    intEn = 2'b10; @(negedge clk);
    check("R9 pin0 masked", {6'd0, sciReq, smiReq}, 8'h01);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule